// File: doc/BRIEF.md
# Clock Source Selector and Tick Divider

This block picks the fast timing source for a small configurable logic device and derives divided tick enables from it for the on-chip consumers. Every oscillator arrives as a one-cycle tick strobe sampled in the single system clock domain. That clock runs faster than any oscillator. Two configuration bits pick the fast source. One bit turns the fast path on. The other picks between the internal ring-oscillator tick and the external pin tick. When the fast path is off, the counter/delay/state-machine consumers and the fabric outputs run straight from the slow RC tick.

The fast tick feeds four dividers: /4, /8, /12 and /64. The converter consumer sees only the /64 enable. The PWM/comparator consumer and the counter/delay/state-machine consumer see /4, /8 and /12. The routing fabric sees only /4 and /12. A fabric output can be held off unless an internal consumer has declared that it uses that divider. A selectable power-down source overrides everything else. While power-down is active, all outputs are silent and all dividers are held at zero.

Every output is a registered enable, one system clock wide. It appears in the cycle after the tick that produced it.

Top module: `clk_src_div`

## Requirements
- R1: The fast source is the ring tick when `fast_en_i`=1 and `fast_sel_i`=1. It is the external tick when `fast_en_i`=1 and `fast_sel_i`=0. It is none when `fast_en_i`=0.
- R2: `adc_en_o` pulses on every 64th fast tick and on no other event. It is the cycle after that tick.
- R3: `pwm_en_o[0]`, `[1]` and `[2]` pulse on every 4th, 8th and 12th fast tick. Each pulse is the cycle after that tick.
- R4: With the fast path on, `fab_en_o[0]` carries the /4 pulse and `fab_en_o[1]` carries the /12 pulse. `cnt_en_o` equals `pwm_en_o`. An undivided fast tick never reaches the fabric.
- R5: With `fast_en_i`=0, every bit of `cnt_en_o` and of `fab_en_o` pulses in the cycle after an RC tick. `adc_en_o` and `pwm_en_o` stay 0.
- R6: Power-down source code `pd_src_i`: 00 never down, 01 always down, 10 taken from `pd_pin_i`, 11 taken from `pd_fab_i`. The selected signal is active high.
- R7: Power-down forces every output to 0 in the following cycle and clears all dividers. After release, each divider needs its full count of fast ticks before its first pulse.
- R8: With `div_gate_i`=1 and the fast path on, `fab_en_o[0]` is suppressed unless `use_div4_i`=1, and `fab_en_o[1]` is suppressed unless `use_div12_i`=1. With `div_gate_i`=0 both pass.
- R9: Any change of {`fast_en_i`,`fast_sel_i`} clears all dividers and silences the outputs for that cycle. The first pulse then needs a full period of ticks.
- R10: The /12 divider wraps from 11 to 0. Every output pulse is exactly one system clock wide.
- R11: While `rst_ni` is low, and right after it rises, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rc_tick_i | input | 1 | Slow RC oscillator tick strobe |
| ring_tick_i | input | 1 | Ring oscillator tick strobe |
| ext_tick_i | input | 1 | External pin clock tick strobe |
| fast_en_i | input | 1 | Fast path enable |
| fast_sel_i | input | 1 | Fast source pick: 1 ring, 0 external |
| pd_src_i | input | 2 | Power-down source code |
| pd_pin_i | input | 1 | Power-down request from a pin |
| pd_fab_i | input | 1 | Power-down request from the fabric |
| div_gate_i | input | 1 | 1 = gate fabric outputs that are not in use |
| use_div4_i | input | 1 | Internal consumer uses the /4 divider |
| use_div12_i | input | 1 | Internal consumer uses the /12 divider |
| adc_en_o | output | 1 | Converter enable (/64) |
| pwm_en_o | output | 3 | PWM/comparator enables: /4, /8, /12 |
| cnt_en_o | output | 3 | Counter/delay/FSM enables |
| fab_en_o | output | 2 | Fabric enables: [0] /4, [1] /12 |

## Verification
The ring, external and RC ticks run with three different repeat patterns: ring ticks on four cycles of every five, external ticks every third cycle, and RC ticks every second cycle. Because of this, a wrong source pick changes the pulse spacing on every output. The RC-only mode shows whether the fast path has been bypassed rather than divided. Power-down is driven from each of the four source codes while the unselected requests toggle. This separates the source pick from the override itself. Source switches in mid-count, together with every gate/use combination, expose dividers that are not cleared and fabric gating that ignores the consumer flags.

// File: rtl/clk_src_div_pkg.sv
package clk_src_div_pkg;
  typedef enum logic [1:0] {
    PD_NEVER  = 2'b00,
    PD_ALWAYS = 2'b01,
    PD_PIN    = 2'b10,
    PD_FABRIC = 2'b11
  } pd_src_e;

  localparam int unsigned DIV_LO  = 4;
  localparam int unsigned DIV_MID = 8;
  localparam int unsigned DIV_HI  = 12;
  localparam int unsigned DIV_ADC = 64;
  localparam int unsigned N_CONS  = 3;
endpackage

// File: rtl/clk_src_mux.sv
module clk_src_mux (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ring_tick_i,
  input  logic ext_tick_i,
  input  logic fast_en_i,
  input  logic fast_sel_i,
  output logic fast_tick_o,
  output logic sel_chg_o
);
  logic [1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 2'b00;
    else         sel_q <= {fast_en_i, fast_sel_i};
  end

  assign sel_chg_o   = (sel_q != {fast_en_i, fast_sel_i});
  assign fast_tick_o = fast_en_i & (fast_sel_i ? ring_tick_i : ext_tick_i);
endmodule

// File: rtl/pd_select.sv
module pd_select
  import clk_src_div_pkg::*;
(
  input  logic [1:0] pd_src_i,
  input  logic       pd_pin_i,
  input  logic       pd_fab_i,
  output logic       pd_o
);
  always_comb begin
    unique case (pd_src_e'(pd_src_i))
      PD_NEVER:  pd_o = 1'b0;
      PD_ALWAYS: pd_o = 1'b1;
      PD_PIN:    pd_o = pd_pin_i;
      PD_FABRIC: pd_o = pd_fab_i;
      default:   pd_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/tick_div.sv
module tick_div #(
  parameter int unsigned N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic hit_o
);
  localparam int unsigned W    = (N > 1) ? $clog2(N) : 1;
  localparam bit          POW2 = ((N & (N - 1)) == 0);
  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W-1:0] cnt_q;
  logic         at_last;

  assign at_last = (cnt_q == LAST);

  generate
    if (POW2) begin : g_pow2
      // natural wrap of a W-bit counter
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (tick_i) cnt_q <= cnt_q + 1'b1;
      end
    end else begin : g_mod
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (tick_i) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
      end
    end
  endgenerate

  assign hit_o = tick_i & at_last & ~clr_i;
endmodule

// File: rtl/clk_src_div.sv
module clk_src_div
  import clk_src_div_pkg::*;
#(
  parameter int unsigned DIV_A = DIV_LO,
  parameter int unsigned DIV_B = DIV_MID,
  parameter int unsigned DIV_C = DIV_HI,
  parameter int unsigned DIV_X = DIV_ADC
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rc_tick_i,
  input  logic        ring_tick_i,
  input  logic        ext_tick_i,
  input  logic        fast_en_i,
  input  logic        fast_sel_i,
  input  logic [1:0]  pd_src_i,
  input  logic        pd_pin_i,
  input  logic        pd_fab_i,
  input  logic        div_gate_i,
  input  logic        use_div4_i,
  input  logic        use_div12_i,
  output logic        adc_en_o,
  output logic [N_CONS-1:0] pwm_en_o,
  output logic [N_CONS-1:0] cnt_en_o,
  output logic [1:0]  fab_en_o
);
  localparam int unsigned NDIV = N_CONS + 1;
  localparam int unsigned DIVS [NDIV] = '{DIV_A, DIV_B, DIV_C, DIV_X};

  logic            fast_tick, sel_chg, pd, clr;
  logic [NDIV-1:0] hit;
  logic [1:0]      fab_pass;

  clk_src_mux u_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ring_tick_i (ring_tick_i),
    .ext_tick_i  (ext_tick_i),
    .fast_en_i   (fast_en_i),
    .fast_sel_i  (fast_sel_i),
    .fast_tick_o (fast_tick),
    .sel_chg_o   (sel_chg)
  );

  pd_select u_pd (
    .pd_src_i (pd_src_i),
    .pd_pin_i (pd_pin_i),
    .pd_fab_i (pd_fab_i),
    .pd_o     (pd)
  );

  assign clr = pd | sel_chg;

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    tick_div #(.N(DIVS[g])) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .tick_i (fast_tick),
      .hit_o  (hit[g])
    );
  end

  // fabric gating: pass when ungated or still used internally
  assign fab_pass[0] = ~div_gate_i | use_div4_i;
  assign fab_pass[1] = ~div_gate_i | use_div12_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adc_en_o <= 1'b0;
      pwm_en_o <= '0;
      cnt_en_o <= '0;
      fab_en_o <= '0;
    end else if (clr) begin
      adc_en_o <= 1'b0;
      pwm_en_o <= '0;
      cnt_en_o <= '0;
      fab_en_o <= '0;
    end else if (fast_en_i) begin
      adc_en_o <= hit[N_CONS];
      pwm_en_o <= hit[N_CONS-1:0];
      cnt_en_o <= hit[N_CONS-1:0];
      fab_en_o <= {hit[2] & fab_pass[1], hit[0] & fab_pass[0]};
    end else begin
      adc_en_o <= 1'b0;
      pwm_en_o <= '0;
      cnt_en_o <= {N_CONS{rc_tick_i}};
      fab_en_o <= {2{rc_tick_i}};
    end
  end
endmodule

// File: rtl/clk_src_div_chk.sv
module clk_src_div_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rc_tick_i,
  input logic       ring_tick_i,
  input logic       ext_tick_i,
  input logic       fast_en_i,
  input logic       fast_sel_i,
  input logic [1:0] pd_src_i,
  input logic       pd_pin_i,
  input logic       pd_fab_i,
  input logic       div_gate_i,
  input logic       use_div4_i,
  input logic       use_div12_i,
  input logic       adc_en_o,
  input logic [2:0] pwm_en_o,
  input logic [2:0] cnt_en_o,
  input logic [1:0] fab_en_o
);
  assert_adc_needs_fast_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_en_o |-> $past(fast_en_i));

  assert_adc_aligns_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_en_o |-> (pwm_en_o[1] && pwm_en_o[0]));

  assert_div12_on_div4_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_en_o[2] |-> pwm_en_o[0]);

  assert_fab_divided_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fast_en_i) && fab_en_o[0]) |-> pwm_en_o[0]);

  assert_forced_pd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_src_i == 2'b01) |=> (!adc_en_o && pwm_en_o == 3'b0 && cnt_en_o == 3'b0 && fab_en_o == 2'b0));

  assert_gate_div4_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_en_i && div_gate_i && !use_div4_i) |=> !fab_en_o[0]);

  assert_gate_div12_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_en_i && div_gate_i && !use_div12_i) |=> !fab_en_o[1]);

  assert_sel_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({fast_en_i, fast_sel_i} != $past({fast_en_i, fast_sel_i})) |=> (!adc_en_o && pwm_en_o == 3'b0));

  assert_pulse_width_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_en_o[2] |=> !pwm_en_o[2]);
endmodule

bind clk_src_div clk_src_div_chk u_chk (.*);

// File: tb/clk_src_div_tb.sv
`timescale 1ns/1ps
module clk_src_div_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rc_t = 0, ring_t = 0, ext_t = 0;
  logic fen = 0, fsel = 0, pd_pin = 0, pd_fab = 0, gate = 0, u4 = 0, u12 = 0;
  logic [1:0] pd_src = 2'b00;
  logic adc;
  logic [2:0] pwm, cnt;
  logic [1:0] fab;

  // configuration requested by the phases; applied at the next negedge
  logic c_fen = 0, c_fsel = 0, c_pin = 0, c_fab = 0, c_gate = 0, c_u4 = 0, c_u12 = 0;
  logic [1:0] c_pd = 2'b00;
  logic c_pin_toggle = 0, c_fab_toggle = 0;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  string tag = "";

  typedef struct {
    logic       adc;
    logic [2:0] pwm;
    logic [2:0] cnt;
    logic [1:0] fab;
    string      tag;
  } exp_t;
  exp_t q[$];

  // reference state
  int m4 = 0, m8 = 0, m12 = 0, m64 = 0;
  logic [1:0] m_prev = 2'b00;

  always #5 clk = ~clk;

  clk_src_div u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rc_tick_i(rc_t), .ring_tick_i(ring_t), .ext_tick_i(ext_t),
    .fast_en_i(fen), .fast_sel_i(fsel), .pd_src_i(pd_src), .pd_pin_i(pd_pin), .pd_fab_i(pd_fab),
    .div_gate_i(gate), .use_div4_i(u4), .use_div12_i(u12),
    .adc_en_o(adc), .pwm_en_o(pwm), .cnt_en_o(cnt), .fab_en_o(fab)
  );

  function automatic logic step_cnt(ref int c, input int n, input logic t);
    logic h;
    h = t && (c == n - 1);
    if (t) c = (c == n - 1) ? 0 : c + 1;
    return h;
  endfunction

  function automatic exp_t model();
    exp_t e;
    logic pd, chg, ft, h4, h8, h12, h64;
    e.tag = tag;
    case (pd_src)            // R6 encoding
      2'b00: pd = 1'b0;
      2'b01: pd = 1'b1;
      2'b10: pd = pd_pin;
      default: pd = pd_fab;
    endcase
    chg = ({fen, fsel} != m_prev);
    m_prev = {fen, fsel};
    ft = fen && (fsel ? ring_t : ext_t);   // R1
    if (pd || chg) begin                   // R7, R9
      m4 = 0; m8 = 0; m12 = 0; m64 = 0;
      e.adc = 0; e.pwm = 0; e.cnt = 0; e.fab = 0;
      return e;
    end
    h4 = step_cnt(m4, 4, ft);
    h8 = step_cnt(m8, 8, ft);
    h12 = step_cnt(m12, 12, ft);
    h64 = step_cnt(m64, 64, ft);
    if (fen) begin
      e.adc = h64;
      e.pwm = {h12, h8, h4};
      e.cnt = {h12, h8, h4};
      e.fab = {h12 && (!gate || u12), h4 && (!gate || u4)};   // R4, R8
    end else begin                                             // R5
      e.adc = 0; e.pwm = 0;
      e.cnt = {3{rc_t}};
      e.fab = {2{rc_t}};
    end
    return e;
  endfunction

  task automatic run(input int n, input string t);
    tag = t;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fen = c_fen; fsel = c_fsel; pd_src = c_pd; gate = c_gate; u4 = c_u4; u12 = c_u12;
      pd_pin = c_pin_toggle ? (cyc % 7 < 3) : c_pin;
      pd_fab = c_fab_toggle ? (cyc % 11 < 5) : c_fab;
      ring_t = (cyc % 5 != 0);
      ext_t  = (cyc % 3 == 0);
      rc_t   = (cyc % 2 == 0);
      cyc++;
      q.push_back(model());
    end
  endtask

  task automatic cmp(input string f, input string t, input logic [2:0] act, input logic [2:0] ex);
    checks++;
    if (act !== ex) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", t, f, cyc, act, ex);
    end
  endtask

  // monitor: compare outputs registered at the edge after each drive
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp("adc R2", e.tag, {2'b0, adc}, {2'b0, e.adc});
        cmp("pwm R3 R10", e.tag, pwm, e.pwm);
        cmp("cnt R4 R5", e.tag, cnt, e.cnt);
        cmp("fab R4 R5 R8", e.tag, {1'b0, fab}, {1'b0, e.fab});
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R11: outputs quiet in and after reset
    repeat (3) @(negedge clk);
    cmp("reset", "R11", {adc, pwm[1:0]}, 3'b0);
    cmp("reset", "R11", {fab, 1'b0}, 3'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    cmp("reset", "R11", cnt, 3'b0);

    c_fen = 1; c_fsel = 1;
    run(400, "R1 R2 R3 ring");
    c_fsel = 0;
    run(400, "R1 R2 R3 R9 ext");
    c_fen = 0;
    run(60, "R5 rc");
    c_fen = 1; c_fsel = 1;
    run(37, "R9 mid-count switch");
    c_fsel = 0;
    run(90, "R9 restart");

    // power-down sources, R6 R7
    c_pd = 2'b01;
    run(40, "R6 R7 forced");
    c_pd = 2'b10; c_pin_toggle = 1; c_fab_toggle = 1;
    run(300, "R6 R7 pin");
    c_pd = 2'b11;
    run(300, "R6 R7 fabric");
    c_pd = 2'b00;
    run(200, "R6 never");
    c_pin_toggle = 0; c_fab_toggle = 0;
    c_fen = 0; c_pd = 2'b10; c_pin = 1;
    run(20, "R5 R7 rc down");
    c_pin = 0;
    run(20, "R5 rc up");

    // gating, R8
    c_fen = 1; c_fsel = 1;
    for (int k = 0; k < 4; k++) begin
      c_gate = 1; c_u4 = k[0]; c_u12 = k[1];
      run(120, "R8 gated");
    end
    c_gate = 0; c_u4 = 0; c_u12 = 0;
    run(120, "R8 ungated");

    wait (q.size() == 0);
    @(posedge clk); #3;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule